// File: doc/BRIEF.md
# Register-programmed raster timing generator

This block derives the horizontal and vertical timing of a raster display from a small bank of byte-wide registers that a host writes one index at a time. Each clock of `clk_i` is one character clock, i.e. eight pixels. A horizontal counter runs over the character positions of a line. A vertical counter advances once per line. From the two counts the block produces display enable, blanking and the two sync pulses. It also outputs the current column and row addresses and a 16-bit start address for the memory fetch logic.

Totals are stored with fixed negative offsets. Vertical values are ten bits wide, and their upper bits are packed into an overflow register and a scan register. Sync end and blank end are short fields. The block compares them modulo against the low bits of the running count. A host write lands in a shadow copy. That copy is moved to the working copy only at the frame boundary, so a write never disturbs the frame being shown.

Top module: `crt_timing_gen`

## Requirements
- R1: A line lasts h_total+5 character clocks (h_total at index 0x00). `char_col_o` counts 0 to h_total+4 and then wraps to 0.
- R2: A frame lasts v_total+2 lines, and `scan_row_o` counts the lines from 0. Ten-bit vertical values take their low byte from an index and their high bits from the overflow register at index 0x07. The mapping is: bit 0 = v_total[8], bit 1 = v_disp_end[8], bit 2 = v_sync_start[8], bit 3 = v_blank_start[8], bit 5 = v_total[9], bit 6 = v_disp_end[9], bit 7 = v_sync_start[9]. The scan register at index 0x09 holds v_blank_start[9] in bit 5. The low bytes are at these indices: v_total 0x06, v_sync_start 0x10, v_disp_end 0x12, v_blank_start 0x15.
- R3: `de_o` is high exactly when the column is at most h_disp_end (index 0x01) and the line is at most v_disp_end.
- R4: hsync becomes active on the column equal to h_sync_start (index 0x04). It stays active until the first later column whose low 5 bits equal bits [4:0] of index 0x05, and that column is excluded. Horizontal blanking starts one column after h_blank_start (index 0x02). It stops at the first column whose low 5 bits equal bits [4:0] of index 0x03. `blank_o` is the OR of horizontal and vertical blanking.
- R5: vsync becomes active on the line equal to v_sync_start. It stops at the first later line whose low 4 bits equal bits [3:0] of index 0x11. Vertical blanking starts one line after v_blank_start. It stops at the first line whose low 8 bits equal index 0x16.
- R6: A sync start that the counter never reaches produces no sync pulse at all, so that output stays at its inactive level. Examples are h_sync_start 0xFF on a short line, or v_sync_start 0x3FF.
- R7: When bit 7 of index 0x09 is set, `scan_row_o` is the line count shifted right by one, so each row is output on two lines. When the bit is clear, it is the line count itself.
- R8: `start_addr_o` is {index 0x0C, index 0x0D}, with the high byte first.
- R9: While bit 7 of index 0x11 is set, writes to indices 0x00 to 0x07 are ignored. Writing 0x11 with bit 7 clear removes the protection.
- R10: Register writes take effect at the first line of the next frame. The frame in progress keeps its old timing.
- R11: `hsync_inv_i` and `vsync_inv_i` each invert their sync output; 1 means active-low.
- R12: After reset the timing is 640x480, which is 100 character clocks by 525 lines. Display covers columns 0 to 79 and lines 0 to 479. hsync covers columns 82 to 93, and horizontal blanking covers 80 to 97. vsync covers lines 490 and 491, and vertical blanking covers 480 to 523. Start address is 0 and scan doubling is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register index |
| reg_wdata_i | input | 8 | Register write data |
| hsync_inv_i | input | 1 | 1 = hsync active low |
| vsync_inv_i | input | 1 | 1 = vsync active low |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| blank_o | output | 1 | Horizontal or vertical blanking |
| de_o | output | 1 | Display enable |
| char_col_o | output | 9 | Current character column |
| scan_row_o | output | 11 | Current row address |
| start_addr_o | output | 16 | Display start address |

## Verification
The bench checks every output on every clock of whole frames. It uses four register settings. The first is the 640x480 reset timing, which shows that the offsets and the overflow bits are decoded correctly. The second is a small 10x6 frame in which the sync and blank end fields wrap modulo, so a misplaced start or end is visible on single columns. The third is the same frame with scan doubling and an unreachable sync start, which separates the suppression and row halving from the normal path. The last setting is written while protection is on and again after it is removed; the frame that follows separates ignored writes from accepted ones. Writes are issued mid-frame, and the bench checks that the current frame keeps its geometry.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int HVAL_W = 8;
  localparam int VVAL_W = 10;
  localparam int HSE_W  = 5;
  localparam int HBE_W  = 5;
  localparam int VSE_W  = 4;
  localparam int VBE_W  = 8;
  localparam int ADDR_W = 5;
  localparam int SA_W   = 16;
  localparam int PROT_LIMIT = 8;

  localparam logic [ADDR_W-1:0] IX_HTOT = 5'h00;
  localparam logic [ADDR_W-1:0] IX_HDE  = 5'h01;
  localparam logic [ADDR_W-1:0] IX_HBS  = 5'h02;
  localparam logic [ADDR_W-1:0] IX_HBE  = 5'h03;
  localparam logic [ADDR_W-1:0] IX_HSS  = 5'h04;
  localparam logic [ADDR_W-1:0] IX_HSE  = 5'h05;
  localparam logic [ADDR_W-1:0] IX_VTOT = 5'h06;
  localparam logic [ADDR_W-1:0] IX_OVF  = 5'h07;
  localparam logic [ADDR_W-1:0] IX_SCAN = 5'h09;
  localparam logic [ADDR_W-1:0] IX_SAH  = 5'h0C;
  localparam logic [ADDR_W-1:0] IX_SAL  = 5'h0D;
  localparam logic [ADDR_W-1:0] IX_VSS  = 5'h10;
  localparam logic [ADDR_W-1:0] IX_VSE  = 5'h11;
  localparam logic [ADDR_W-1:0] IX_VDE  = 5'h12;
  localparam logic [ADDR_W-1:0] IX_VBS  = 5'h15;
  localparam logic [ADDR_W-1:0] IX_VBE  = 5'h16;

  typedef struct packed {
    logic [HVAL_W-1:0] h_total;
    logic [HVAL_W-1:0] h_disp_end;
    logic [HVAL_W-1:0] h_blank_start;
    logic [HBE_W-1:0]  h_blank_end;
    logic [HVAL_W-1:0] h_sync_start;
    logic [HSE_W-1:0]  h_sync_end;
    logic [VVAL_W-1:0] v_total;
    logic [VVAL_W-1:0] v_disp_end;
    logic [VVAL_W-1:0] v_blank_start;
    logic [VBE_W-1:0]  v_blank_end;
    logic [VVAL_W-1:0] v_sync_start;
    logic [VSE_W-1:0]  v_sync_end;
    logic              dbl;
    logic [SA_W-1:0]   start_addr;
  } timing_t;

  // 640x480: 100 chars x 525 lines
  localparam timing_t TIMING_RST = '{
    h_total:       8'd95,
    h_disp_end:    8'd79,
    h_blank_start: 8'd79,
    h_blank_end:   5'd2,
    h_sync_start:  8'd82,
    h_sync_end:    5'd30,
    v_total:       10'd523,
    v_disp_end:    10'd479,
    v_blank_start: 10'd479,
    v_blank_end:   8'd12,
    v_sync_start:  10'd490,
    v_sync_end:    4'd12,
    dbl:           1'b0,
    start_addr:    16'h0000
  };
endpackage

// File: rtl/crt_reg_bank.sv
module crt_reg_bank
  import crt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              load_i,
  output timing_t           act_o
);
  timing_t shd_q, act_q;
  logic    prot_q;
  logic    locked;

  assign locked = prot_q && (addr_i < ADDR_W'(PROT_LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q  <= TIMING_RST;
      prot_q <= 1'b0;
    end else if (we_i && !locked) begin
      unique case (addr_i)
        IX_HTOT: shd_q.h_total       <= wdata_i;
        IX_HDE:  shd_q.h_disp_end    <= wdata_i;
        IX_HBS:  shd_q.h_blank_start <= wdata_i;
        IX_HBE:  shd_q.h_blank_end   <= wdata_i[HBE_W-1:0];
        IX_HSS:  shd_q.h_sync_start  <= wdata_i;
        IX_HSE:  shd_q.h_sync_end    <= wdata_i[HSE_W-1:0];
        IX_VTOT: shd_q.v_total[7:0]  <= wdata_i;
        IX_OVF: begin
          shd_q.v_total[8]       <= wdata_i[0];
          shd_q.v_disp_end[8]    <= wdata_i[1];
          shd_q.v_sync_start[8]  <= wdata_i[2];
          shd_q.v_blank_start[8] <= wdata_i[3];
          shd_q.v_total[9]       <= wdata_i[5];
          shd_q.v_disp_end[9]    <= wdata_i[6];
          shd_q.v_sync_start[9]  <= wdata_i[7];
        end
        IX_SCAN: begin
          shd_q.v_blank_start[9] <= wdata_i[5];
          shd_q.dbl              <= wdata_i[7];
        end
        IX_SAH:  shd_q.start_addr[15:8]   <= wdata_i;
        IX_SAL:  shd_q.start_addr[7:0]    <= wdata_i;
        IX_VSS:  shd_q.v_sync_start[7:0]  <= wdata_i;
        IX_VSE: begin
          shd_q.v_sync_end <= wdata_i[VSE_W-1:0];
          prot_q           <= wdata_i[7];
        end
        IX_VDE:  shd_q.v_disp_end[7:0]    <= wdata_i;
        IX_VBS:  shd_q.v_blank_start[7:0] <= wdata_i;
        IX_VBE:  shd_q.v_blank_end        <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= TIMING_RST;
    else if (load_i) act_q <= shd_q;
  end

  assign act_o = act_q;

  // R10
  active_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_q));

  // R9
  prot_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && locked) |=> $stable({shd_q.h_total, shd_q.h_disp_end, shd_q.h_blank_start,
                                  shd_q.h_blank_end, shd_q.h_sync_start, shd_q.h_sync_end,
                                  shd_q.v_total}));
endmodule

// File: rtl/crt_axis.sv
module crt_axis #(
  parameter int VAL_W = 8,
  parameter int SE_W  = 5,
  parameter int BE_W  = 5,
  parameter int OFS   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [VAL_W-1:0] total_i,
  input  logic [VAL_W-1:0] disp_end_i,
  input  logic [VAL_W-1:0] blank_start_i,
  input  logic [BE_W-1:0]  blank_end_i,
  input  logic [VAL_W-1:0] sync_start_i,
  input  logic [SE_W-1:0]  sync_end_i,
  output logic [VAL_W:0]   cnt_o,
  output logic             last_o,
  output logic             de_o,
  output logic             blank_o,
  output logic             sync_o
);
  localparam int CW = VAL_W + 1;

  logic [CW-1:0] cnt_q, nxt, last_val;
  logic          blank_q, sync_q;

  assign last_val = {1'b0, total_i} + CW'(OFS - 1);
  assign last_o   = (cnt_q == last_val);
  assign nxt      = last_o ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      blank_q <= 1'b0;
      sync_q  <= 1'b0;
    end else if (step_i) begin
      cnt_q <= nxt;
      // start wins over end; end fields compare modulo
      if (nxt == {1'b0, sync_start_i})            sync_q <= 1'b1;
      else if (nxt[SE_W-1:0] == sync_end_i)       sync_q <= 1'b0;
      if (nxt == {1'b0, blank_start_i} + 1'b1)    blank_q <= 1'b1;
      else if (nxt[BE_W-1:0] == blank_end_i)      blank_q <= 1'b0;
    end
  end

  assign cnt_o   = cnt_q;
  assign de_o    = (cnt_q <= {1'b0, disp_end_i});
  assign blank_o = blank_q;
  assign sync_o  = sync_q;

  // R1 R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_val);

  // R1 R2
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && last_o) |=> cnt_q == '0);

  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_q));

  // R4 R5
  sync_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_q) |-> cnt_q == {1'b0, $past(sync_start_i)});
endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen
  import crt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              hsync_inv_i,
  input  logic              vsync_inv_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              blank_o,
  output logic              de_o,
  output logic [HVAL_W:0]   char_col_o,
  output logic [VVAL_W:0]   scan_row_o,
  output logic [SA_W-1:0]   start_addr_o
);
  timing_t           act;
  logic              h_last, v_last, h_de, v_de, h_blank, v_blank, h_sync, v_sync;
  logic [HVAL_W:0]   h_cnt;
  logic [VVAL_W:0]   v_cnt;

  crt_reg_bank u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .load_i  (h_last && v_last),
    .act_o   (act)
  );

  crt_axis #(.VAL_W(HVAL_W), .SE_W(HSE_W), .BE_W(HBE_W), .OFS(5)) u_h (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .step_i        (1'b1),
    .total_i       (act.h_total),
    .disp_end_i    (act.h_disp_end),
    .blank_start_i (act.h_blank_start),
    .blank_end_i   (act.h_blank_end),
    .sync_start_i  (act.h_sync_start),
    .sync_end_i    (act.h_sync_end),
    .cnt_o         (h_cnt),
    .last_o        (h_last),
    .de_o          (h_de),
    .blank_o       (h_blank),
    .sync_o        (h_sync)
  );

  crt_axis #(.VAL_W(VVAL_W), .SE_W(VSE_W), .BE_W(VBE_W), .OFS(2)) u_v (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .step_i        (h_last),
    .total_i       (act.v_total),
    .disp_end_i    (act.v_disp_end),
    .blank_start_i (act.v_blank_start),
    .blank_end_i   (act.v_blank_end),
    .sync_start_i  (act.v_sync_start),
    .sync_end_i    (act.v_sync_end),
    .cnt_o         (v_cnt),
    .last_o        (v_last),
    .de_o          (v_de),
    .blank_o       (v_blank),
    .sync_o        (v_sync)
  );

  assign hsync_o      = h_sync ^ hsync_inv_i;
  assign vsync_o      = v_sync ^ vsync_inv_i;
  assign blank_o      = h_blank | v_blank;
  assign de_o         = h_de & v_de;
  assign char_col_o   = h_cnt;
  assign scan_row_o   = act.dbl ? {1'b0, v_cnt[VVAL_W:1]} : v_cnt;
  assign start_addr_o = act.start_addr;

  // R2
  line_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_cnt != $past(v_cnt)) |-> $past(h_last));
endmodule

// File: tb/crt_timing_gen_tb.sv
module crt_timing_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        hinv = 1'b0, vinv = 1'b0;
  logic        hsync, vsync, blank, de;
  logic [8:0]  col;
  logic [10:0] row;
  logic [15:0] sa;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crt_timing_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .hsync_inv_i(hinv), .vsync_inv_i(vinv), .hsync_o(hsync), .vsync_o(vsync),
    .blank_o(blank), .de_o(de), .char_col_o(col), .scan_row_o(row), .start_addr_o(sa)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  // one full frame starting at column 0, line 0; ranges are [lo,hi)
  task automatic run_frame(input string t, input int hn, input int vn, input int hde,
                           input int hb0, input int hb1, input int hs0, input int hs1,
                           input int vde, input int vb0, input int vb1,
                           input int vs0, input int vs1, input bit dbl, input int exp_sa);
    for (int l = 0; l < vn; l++) begin
      for (int c = 0; c < hn; c++) begin
        chk({t, " R1 col"}, int'(col), c);
        chk({t, " R2 R7 row"}, int'(row), dbl ? l / 2 : l);
        chk({t, " R3 de"}, int'(de), int'(c <= hde && l <= vde));
        chk({t, " R4 R5 blank"}, int'(blank),
            int'((c >= hb0 && c < hb1) || (l >= vb0 && l < vb1)));
        chk({t, " R4 R11 hsync"}, int'(hsync), int'((c >= hs0 && c < hs1) ^ hinv));
        chk({t, " R5 R11 vsync"}, int'(vsync), int'((l >= vs0 && l < vs1) ^ vinv));
        chk({t, " R8 start"}, int'(sa), exp_sa);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // F0: reset timing; config A written mid-frame must not alter it
    fork
      run_frame("R12 R10", 100, 525, 79, 80, 98, 82, 94, 479, 480, 524, 490, 492, 1'b0, 0);
      begin
        repeat (50) @(negedge clk);
        wr(5'h00, 8'd5); wr(5'h01, 8'd5); wr(5'h02, 8'd5); wr(5'h03, 8'd8);
        wr(5'h04, 8'd7); wr(5'h05, 8'd9); wr(5'h06, 8'd4); wr(5'h07, 8'h00);
        wr(5'h09, 8'h00); wr(5'h0C, 8'h00); wr(5'h0D, 8'h00); wr(5'h10, 8'd4);
        wr(5'h11, 8'd5); wr(5'h12, 8'd3); wr(5'h15, 8'd3); wr(5'h16, 8'd5);
      end
    join
    // F1: config A, hsync inverted; config B written mid-frame
    hinv = 1'b1; #1;
    fork
      run_frame("R10 R11 cfgA", 10, 6, 5, 6, 8, 7, 9, 3, 4, 5, 4, 5, 1'b0, 0);
      begin
        repeat (5) @(negedge clk);
        wr(5'h04, 8'hFF); wr(5'h07, 8'h84); wr(5'h09, 8'h80);
        wr(5'h0C, 8'h12); wr(5'h0D, 8'h34); wr(5'h10, 8'hFF); wr(5'h11, 8'h85);
      end
    join
    // F2: config B, syncs suppressed, doubling; protected write of h_total
    hinv = 1'b0; vinv = 1'b1; #1;
    fork
      run_frame("R6 R7 R8 cfgB", 10, 6, 5, 6, 8, 99, 99, 3, 4, 5, 999, 999, 1'b1, 16'h1234);
      begin
        repeat (5) @(negedge clk);
        wr(5'h00, 8'd9);
      end
    join
    // F3: protected write ignored; unprotect then change h_total
    vinv = 1'b0; #1;
    fork
      run_frame("R9 locked", 10, 6, 5, 6, 8, 99, 99, 3, 4, 5, 999, 999, 1'b1, 16'h1234);
      begin
        repeat (5) @(negedge clk);
        wr(5'h11, 8'h05); wr(5'h00, 8'd7);
      end
    join
    // F4: unlocked write took effect, 12-column lines
    run_frame("R9 R6 unlocked", 12, 6, 5, 6, 8, 99, 99, 3, 4, 5, 999, 999, 1'b1, 16'h1234);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=%0d exp=%0d", WATCHDOG, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule